// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 8-bit buses, called A and B, and keeps one storage register for each of them. The A register samples the A bus on a rising edge of its own capture clock. The B register samples the B bus on a rising edge of a second, independent capture clock. When the active-low drive enable is low, exactly one bus is driven. The direction input picks which one. The bus being driven receives either live data from the other bus or the value held in that bus's register, as chosen by a per-destination source select. When the drive enable is high, both buses are released. The registers still capture in that state, so data can be parked and replayed later.

Each bus appears as three separate signals: an input vector, an output vector and a drive flag. This lets the three-state behaviour be observed without bidirectional nets. The live path is purely combinational. Only the two registers hold state. Both registers clear on a synchronous active-high reset, which is sampled in each capture clock domain.

Top module: `regbus_xcvr`

## Requirements
- R1: While `rst` is high, a rising capture edge clears that side's register to zero. After reset, a replay of either register reads 0x00.
- R2: A rising edge of `clk_cap_a` stores `a_in` in the A register. A rising edge of `clk_cap_b` stores `b_in` in the B register. A register holds its value between its own edges.
- R3: With `drive_en_n` = 1, both `a_drive` and `b_drive` are 0.
- R4: With `drive_en_n` = 0 and `dir_a2b` = 1, only `b_drive` is 1. With `dir_a2b` = 0, only `a_drive` is 1. The two flags are never 1 together.
- R5: While B is driven, `sel_b_stored` = 0 puts live `a_in` on `b_out`, and `sel_b_stored` = 1 puts the A register on `b_out`.
- R6: While A is driven, `sel_a_stored` = 0 puts live `b_in` on `a_out`, and `sel_a_stored` = 1 puts the B register on `a_out`.
- R7: Both registers capture normally while `drive_en_n` = 1, and capturing does not raise any drive flag.
- R8: A capture edge on one side never changes the other side's register.
- R9: An output vector whose drive flag is 0 reads 0x00.
- R10: The live path follows its input in the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cap_a | input | 1 | Capture clock for the A register |
| clk_cap_b | input | 1 | Capture clock for the B register |
| rst | input | 1 | Synchronous active-high reset, sampled on each capture clock |
| drive_en_n | input | 1 | Active-low drive enable; high isolates both buses |
| dir_a2b | input | 1 | 1: B is driven from A side; 0: A is driven from B side |
| sel_b_stored | input | 1 | Source for B output: 0 live A, 1 A register |
| sel_a_stored | input | 1 | Source for A output: 0 live B, 1 B register |
| a_in | input | 8 | Value present on bus A |
| a_out | output | 8 | Value driven onto bus A |
| a_drive | output | 1 | Bus A is being driven |
| b_in | input | 8 | Value present on bus B |
| b_out | output | 8 | Value driven onto bus B |
| b_drive | output | 1 | Bus B is being driven |

## Verification
The live paths are tried with several distinct byte values, and the input is changed with no clock edge in between. This separates a combinational pass-through from a path that latches. Register replay uses a value that differs from the current bus value, so stored data cannot be confused with live data. Captures are done in isolation and one side at a time, and both registers are read back afterwards. This shows that isolation does not block capture and that the two clocks do not disturb each other's register. Every direction and enable combination is checked for which flag is raised and whether the undriven vector reads zero.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic {
        DIR_B_TO_A = 1'b0,
        DIR_A_TO_B = 1'b1
    } dir_e;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_e;

    typedef struct packed {
        logic drv_a;
        logic drv_b;
    } route_t;

    function automatic route_t route_decode(input logic en_n, input dir_e dir);
        route_t r;
        r.drv_b = !en_n && (dir == DIR_A_TO_B);
        r.drv_a = !en_n && (dir == DIR_B_TO_A);
        return r;
    endfunction

endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (q == '0)); // R1

    AST_CAPTURE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (q == $past(d))); // R2

endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
    import xcvr_pkg::*;
(
    input  logic   en_n,
    input  logic   dir_a2b,
    output route_t route
);

    always_comb begin
        route = route_decode(en_n, dir_e'(dir_a2b));
    end

endmodule

// File: rtl/xcvr_port_mux.sv
module xcvr_port_mux
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    input  logic         sel_stored,
    input  logic         drive,
    output logic [W-1:0] out
);

    logic [W-1:0] picked;

    always_comb begin
        picked = (src_e'(sel_stored) == SRC_STORED) ? stored : live;
    end

    for (genvar i = 0; i < W; i++) begin : g_gate
        assign out[i] = picked[i] & drive;
    end

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
    parameter int W = 8
) (
    input  logic         clk_cap_a,
    input  logic         clk_cap_b,
    input  logic         rst,
    input  logic         drive_en_n,
    input  logic         dir_a2b,
    input  logic         sel_b_stored,
    input  logic         sel_a_stored,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_drive,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_drive
);
    import xcvr_pkg::*;

    logic [W-1:0] held_a;
    logic [W-1:0] held_b;
    route_t       route;

    xcvr_store_reg #(.W(W)) u_store_a (
        .clk(clk_cap_a), .rst(rst), .d(a_in), .q(held_a)
    );

    xcvr_store_reg #(.W(W)) u_store_b (
        .clk(clk_cap_b), .rst(rst), .d(b_in), .q(held_b)
    );

    xcvr_route u_route (
        .en_n(drive_en_n), .dir_a2b(dir_a2b), .route(route)
    );

    assign a_drive = route.drv_a;
    assign b_drive = route.drv_b;

    xcvr_port_mux #(.W(W)) u_mux_b (
        .live(a_in), .stored(held_a), .sel_stored(sel_b_stored),
        .drive(b_drive), .out(b_out)
    );

    xcvr_port_mux #(.W(W)) u_mux_a (
        .live(b_in), .stored(held_b), .sel_stored(sel_a_stored),
        .drive(a_drive), .out(a_out)
    );

    AST_ONE_DRIVER: assert property (@(posedge clk_cap_a) disable iff (rst)
        !(a_drive && b_drive)); // R4

    AST_ISOLATE: assert property (@(posedge clk_cap_a) disable iff (rst)
        drive_en_n |-> (!a_drive && !b_drive)); // R3

    AST_IDLE_ZERO_B: assert property (@(posedge clk_cap_a) disable iff (rst)
        !b_drive |-> (b_out == '0)); // R9

    AST_IDLE_ZERO_A: assert property (@(posedge clk_cap_b) disable iff (rst)
        !a_drive |-> (a_out == '0)); // R9

    AST_LIVE_B: assert property (@(posedge clk_cap_b) disable iff (rst)
        (b_drive && !sel_b_stored) |-> (b_out == a_in)); // R5

endmodule

// File: tb/sim_regbus_xcvr.sv
module sim_regbus_xcvr;

    logic       clk = 0;
    logic       clk_cap_a = 0, clk_cap_b = 0, rst = 1;
    logic       drive_en_n = 1, dir_a2b = 0, sel_b_stored = 0, sel_a_stored = 0;
    logic [7:0] a_in = 0, b_in = 0;
    logic [7:0] a_out, b_out;
    logic       a_drive, b_drive;
    int         n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    regbus_xcvr #(.W(8)) u0 (
        .clk_cap_a(clk_cap_a), .clk_cap_b(clk_cap_b), .rst(rst),
        .drive_en_n(drive_en_n), .dir_a2b(dir_a2b),
        .sel_b_stored(sel_b_stored), .sel_a_stored(sel_a_stored),
        .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
        .b_in(b_in), .b_out(b_out), .b_drive(b_drive)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic pulse(input bit side_a, input bit side_b);
        @(posedge clk);
        if (side_a) clk_cap_a = 1;
        if (side_b) clk_cap_b = 1;
        @(negedge clk);
        clk_cap_a = 0;
        clk_cap_b = 0;
        settle();
    endtask

    task automatic set_ctl(input logic en_n, input logic dir, input logic sb, input logic sa);
        @(negedge clk);
        drive_en_n = en_n; dir_a2b = dir; sel_b_stored = sb; sel_a_stored = sa;
        settle();
    endtask

    task automatic t_reset();
        a_in = 8'hFF; b_in = 8'h3C;
        rst = 1;
        pulse(1, 1);
        pulse(1, 1);
        rst = 0;
        set_ctl(0, 1, 1, 0);
        check("R1 A register cleared", b_out, 8'h00);
        check("R4 b_drive for a2b", {7'd0, b_drive}, 8'h01);
        set_ctl(0, 0, 0, 1);
        check("R1 B register cleared", a_out, 8'h00);
        check("R4 a_drive for b2a", {7'd0, a_drive}, 8'h01);
        check("R4 b_drive low for b2a", {7'd0, b_drive}, 8'h00);
        check("R9 b_out zero undriven", b_out, 8'h00);
    endtask

    task automatic t_isolation();
        a_in = 8'hA7; b_in = 8'h5E;
        set_ctl(1, 1, 0, 0);
        check("R3 a_drive low", {7'd0, a_drive}, 8'h00);
        check("R3 b_drive low", {7'd0, b_drive}, 8'h00);
        check("R9 a_out zero", a_out, 8'h00);
        check("R9 b_out zero", b_out, 8'h00);
        set_ctl(1, 0, 1, 1);
        check("R3 isolation dir0 a_drive", {7'd0, a_drive}, 8'h00);
    endtask

    task automatic t_live();
        set_ctl(0, 1, 0, 0);
        a_in = 8'h5A; settle();
        check("R5 live A on B", b_out, 8'h5A);
        check("R9 a_out zero when b driven", a_out, 8'h00);
        a_in = 8'hA5; settle();
        check("R10 live follows without clock", b_out, 8'hA5);
        set_ctl(0, 0, 0, 0);
        b_in = 8'hC3; settle();
        check("R6 live B on A", a_out, 8'hC3);
        b_in = 8'h18; settle();
        check("R10 live B follows", a_out, 8'h18);
    endtask

    task automatic t_stored();
        set_ctl(0, 1, 1, 0);
        a_in = 8'h77; settle();
        pulse(1, 0);
        a_in = 8'h11; settle();
        check("R2 R5 A register replay", b_out, 8'h77);
        set_ctl(0, 0, 0, 1);
        b_in = 8'hE1; settle();
        pulse(0, 1);
        b_in = 8'h00; settle();
        check("R2 R6 B register replay", a_out, 8'hE1);
    endtask

    task automatic t_capture_isolated();
        set_ctl(1, 0, 0, 0);
        a_in = 8'h9C; b_in = 8'h46; settle();
        pulse(1, 1);
        check("R7 no drive during capture A", {7'd0, a_drive}, 8'h00);
        check("R7 no drive during capture B", {7'd0, b_drive}, 8'h00);
        a_in = 8'h01; b_in = 8'h02;
        set_ctl(0, 1, 1, 0);
        check("R7 A captured while isolated", b_out, 8'h9C);
        set_ctl(0, 0, 0, 1);
        check("R7 B captured while isolated", a_out, 8'h46);
    endtask

    task automatic t_independent();
        a_in = 8'h2B; b_in = 8'hD0; settle();
        pulse(1, 0);
        set_ctl(0, 0, 0, 1);
        check("R8 B register kept after A capture", a_out, 8'h46);
        set_ctl(0, 1, 1, 0);
        check("R8 A register updated", b_out, 8'h2B);
        a_in = 8'h66; b_in = 8'h99; settle();
        pulse(0, 1);
        check("R8 A register kept after B capture", b_out, 8'h2B);
        set_ctl(0, 0, 0, 1);
        check("R8 B register updated", a_out, 8'h99);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_isolation();
        t_live();
        t_stored();
        t_capture_isolated();
        t_independent();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule